// File: doc/BRIEF.md
# Per-CPU Interrupt Claim and Completion Interface

This block is the register face that one processor uses to claim an interrupt and to say that it has finished with it. A software read of the acknowledge register takes the highest-pending interrupt offered by the arbiter. The read succeeds only if that interrupt's priority is strictly more urgent (numerically lower) than the priority now running. On success the block tells the distributor to drop the pending state and makes the claimed interrupt the running one. A write of an interrupt ID to the completion register retires it.

Nesting is kept as a chain. Each claimed ID stores the ID (and priority) that was running when it was taken. Completing the running ID pops back to its stored predecessor. Completing an ID buried deeper in the chain starts a walk, one link per clock, that splices that ID out; the bus ready signal is held low until the walk ends. On completion, a level-sensitive interrupt whose line is still high is handed back to the distributor as pending again.

Top module: `cpu_claim_if`

## Requirements
- R1: After reset the interface enable reads 0 at offset 0x00, the priority mask reads 0xf0 at 0x04, the running priority reads 0x100 at 0x14, and `run_id_o` is 1023.
- R2: A read at offset 0x0C returns `hp_id` and pulses `pend_clr_o` with `pend_clr_id` equal to it, in the same transfer cycle, only if `hp_id` is below NUM_IRQ and `{0,hp_prio}` is strictly below the running priority. Otherwise it returns 1023, gives no pulse and changes no state; an equal priority fails.
- R3: After a successful acknowledge the running ID is the claimed ID and the running priority (offset 0x14) is its priority.
- R4: On a successful acknowledge `pend_clr_all_o` equals the claimed ID's bit in `irq_model_all`: 1 clears pending for all CPUs, 0 for this CPU only.
- R5: A write at offset 0x10 while the running ID is 1023 has no effect: no `pend_set_o` pulse and the running ID and priority stay unchanged.
- R6: A completion write (bits 9:0 = ID) pulses `pend_set_o` with that ID in the write cycle when the ID's `irq_edge` bit is 0 and its `irq_enable`, `irq_level` and `irq_target` bits are all 1; otherwise no pulse.
- R7: Completing the running ID makes its stored predecessor the running ID with that predecessor's priority; the running priority is 0x100 when the predecessor is 1023.
- R8: Completing an ID that is below the running ID in the chain removes it: the running ID is unchanged, and later completions of the running IDs skip the removed one.
- R9: After a completion of a non-running ID is accepted, `bus_ready` is low for exactly one cycle per link examined: d cycles when the ID is the d-th entry below the running ID, and L+1 cycles when it is absent from a chain of L entries below the running ID.
- R10: Writing offset 0x00 bit 0 sets the interface enable (read back at 0x00 and on `iface_en_o`). Writing offset 0x04 stores bits 7:0 as the priority mask (read back at 0x04). A read at offset 0x18 returns `hp_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Transfer request; completes on a cycle with `bus_ready` high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the completing cycle |
| bus_ready | output | 1 | Low while a chain walk is in progress |
| hp_id | input | 10 | Highest-pending ID from the arbiter, 1023 if none |
| hp_prio | input | 8 | Priority of `hp_id` |
| irq_edge | input | NUM_IRQ | Per-ID edge-triggered flag |
| irq_enable | input | NUM_IRQ | Per-ID enable |
| irq_level | input | NUM_IRQ | Per-ID input line level |
| irq_target | input | NUM_IRQ | Per-ID bit: this CPU is a target |
| irq_model_all | input | NUM_IRQ | Per-ID 1:N model flag |
| pend_clr_o | output | 1 | Clear-pending pulse on acknowledge |
| pend_clr_all_o | output | 1 | Clear applies to all CPUs |
| pend_clr_id | output | 10 | ID to clear |
| pend_set_o | output | 1 | Re-pend pulse on completion |
| pend_set_id | output | 10 | ID to re-pend |
| iface_en_o | output | 1 | Interface enable to the arbiter |
| prio_mask_o | output | 8 | Priority mask to the arbiter |
| run_id_o | output | 10 | Running interrupt ID |
| run_prio_o | output | 9 | Running priority |

## Verification
Read data and both pend pulses are combinational within the completing transfer, so the bench samples them one time unit after the falling edge of that cycle, before the rising edge commits it. Running ID and priority change at the edge that ends a transfer, and the bench reads them back by a later transfer. A walk starts at the edge that accepts the completion write; from there the bench counts rising edges with `bus_ready` low to confirm the one-cycle-per-link timing.

// File: rtl/cpuif_pkg.sv
// Shared constants and types for the per-CPU claim/completion interface.
// Assumes 10-bit interrupt IDs with 1023 reserved as "none".
package cpuif_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam int RPRI_W = PRIO_W + 1;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ID_W-1:0]   NO_ID      = 10'd1023;
    localparam logic [RPRI_W-1:0] IDLE_PRIO  = 9'h100;
    localparam logic [PRIO_W-1:0] MASK_RESET = 8'hf0;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_MASK = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_ACK  = 5'h0c;
    localparam logic [ADDR_W-1:0] OFF_DONE = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_RUNP = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_HIGH = 5'h18;

    typedef enum logic {CHAIN_IDLE, CHAIN_WALK} chain_state_t;
endpackage

// File: rtl/cpuif_ctrl_regs.sv
// Interface enable and priority mask registers.
// Assumes write strobes are already qualified by a completed bus transfer.
module cpuif_ctrl_regs
    import cpuif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wdata,
    output logic              iface_en,
    output logic [PRIO_W-1:0] prio_mask
);
    // Hold the enable bit and the mask, loading them on their write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iface_en  <= 1'b0;
            prio_mask <= MASK_RESET;
        end else begin
            if (wr_ctrl) iface_en  <= wdata[0];
            if (wr_mask) prio_mask <= wdata[PRIO_W-1:0];
        end
    end
endmodule

// File: rtl/cpuif_reassert.sv
// Decides whether a completed interrupt must be made pending again.
// Assumes per-ID distributor state arrives as flat vectors indexed by ID.
module cpuif_reassert
    import cpuif_pkg::*;
#(
    parameter int NUM_IRQ = 64
)(
    input  logic               done_en,
    input  logic [ID_W-1:0]    done_id,
    input  logic [NUM_IRQ-1:0] irq_edge,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic [NUM_IRQ-1:0] irq_level,
    input  logic [NUM_IRQ-1:0] irq_target,
    output logic               set_en,
    output logic [ID_W-1:0]    set_id
);
    localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_IRQ);

    logic in_range;

    // Re-pend only level-sensitive, enabled, still-high lines aimed at this CPU.
    always_comb begin
        in_range = done_id < ID_LIMIT;
        set_id   = done_id;
        set_en   = 1'b0;
        if (done_en && in_range) begin
            set_en = !irq_edge[done_id] && irq_enable[done_id]
                     && irq_level[done_id] && irq_target[done_id];
        end
    end
endmodule

// File: rtl/cpuif_nest_chain.sv
// Running-interrupt state plus the per-ID chain of preempted interrupts.
// Push on claim, pop on completion of the running ID, and a multi-cycle
// walk that splices a buried ID out of the chain. Assumes at most one of
// push/pop/unlink per cycle and that none is issued while busy.
module cpuif_nest_chain
    import cpuif_pkg::*;
#(
    parameter int NUM_IRQ = 64
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop_en,
    input  logic              unlink_en,
    input  logic [ID_W-1:0]   unlink_id,
    output logic [ID_W-1:0]   run_id,
    output logic [RPRI_W-1:0] run_prio,
    output logic              busy
);
    localparam int              IDX_W    = $clog2(NUM_IRQ);
    localparam int              STEP_W   = IDX_W + 1;
    localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(NUM_IRQ);
    localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_IRQ);

    logic [ID_W-1:0]   link_id   [NUM_IRQ];
    logic [RPRI_W-1:0] link_prio [NUM_IRQ];

    chain_state_t      state;
    logic [ID_W-1:0]   cursor;
    logic [ID_W-1:0]   victim;
    logic [STEP_W-1:0] steps;
    logic [ID_W-1:0]   cur_link;
    logic              walk_end;

    function automatic logic [IDX_W-1:0] slot(input logic [ID_W-1:0] id);
        return id[IDX_W-1:0];
    endfunction

    // Link of the entry under the cursor and whether the walk stops here.
    always_comb begin
        cur_link = link_id[slot(cursor)];
        walk_end = (cur_link == NO_ID) || (cur_link >= ID_LIMIT)
                   || (steps == STEP_MAX);
    end

    assign busy = (state == CHAIN_WALK);

    // Running state, chain storage and walk sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CHAIN_IDLE;
            run_id   <= NO_ID;
            run_prio <= IDLE_PRIO;
            cursor   <= NO_ID;
            victim   <= NO_ID;
            steps    <= '0;
            for (int i = 0; i < NUM_IRQ; i++) begin
                link_id[i]   <= NO_ID;
                link_prio[i] <= IDLE_PRIO;
            end
        end else begin
            unique case (state)
                CHAIN_IDLE: begin
                    if (push_en) begin
                        link_id[slot(push_id)]   <= run_id;
                        link_prio[slot(push_id)] <= run_prio;
                        run_id   <= push_id;
                        run_prio <= {1'b0, push_prio};
                    end else if (pop_en) begin
                        run_id   <= link_id[slot(run_id)];
                        run_prio <= link_prio[slot(run_id)];
                    end else if (unlink_en) begin
                        state  <= CHAIN_WALK;
                        cursor <= run_id;
                        victim <= unlink_id;
                        steps  <= '0;
                    end
                end
                CHAIN_WALK: begin
                    if (walk_end) begin
                        state <= CHAIN_IDLE;
                    end else if (cur_link == victim) begin
                        link_id[slot(cursor)]   <= link_id[slot(victim)];
                        link_prio[slot(cursor)] <= link_prio[slot(victim)];
                        state <= CHAIN_IDLE;
                    end else begin
                        cursor <= cur_link;
                        steps  <= steps + 1'b1;
                    end
                end
                default: state <= CHAIN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cpu_claim_if.sv
// Per-CPU claim/completion register interface. Decodes the register bus,
// qualifies acknowledges against the running priority, issues pending
// clear/set pulses to the distributor and drives the nesting chain.
// Assumes the arbiter supplies hp_id/hp_prio and the distributor the
// per-ID vectors; a transfer completes on bus_sel && bus_ready.
module cpu_claim_if
    import cpuif_pkg::*;
#(
    parameter int NUM_IRQ = 64
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [4:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_ready,
    input  logic [9:0]         hp_id,
    input  logic [7:0]         hp_prio,
    input  logic [NUM_IRQ-1:0] irq_edge,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic [NUM_IRQ-1:0] irq_level,
    input  logic [NUM_IRQ-1:0] irq_target,
    input  logic [NUM_IRQ-1:0] irq_model_all,
    output logic               pend_clr_o,
    output logic               pend_clr_all_o,
    output logic [9:0]         pend_clr_id,
    output logic               pend_set_o,
    output logic [9:0]         pend_set_id,
    output logic               iface_en_o,
    output logic [7:0]         prio_mask_o,
    output logic [9:0]         run_id_o,
    output logic [8:0]         run_prio_o
);
    localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_IRQ);

    logic            busy;
    logic            rd_xfer, wr_xfer;
    logic            ack_ok, hp_valid;
    logic            done_wr, pop_en, unlink_en;
    logic [ID_W-1:0] done_id;
    logic            unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:ID_W];

    // Transfer qualification and command decode.
    always_comb begin
        bus_ready = !busy;
        rd_xfer   = bus_sel && bus_ready && !bus_wr;
        wr_xfer   = bus_sel && bus_ready && bus_wr;
        hp_valid  = hp_id < ID_LIMIT;
        ack_ok    = rd_xfer && (bus_addr == OFF_ACK) && hp_valid
                    && ({1'b0, hp_prio} < run_prio_o);
        done_id   = bus_wdata[ID_W-1:0];
        done_wr   = wr_xfer && (bus_addr == OFF_DONE) && (run_id_o != NO_ID);
        pop_en    = done_wr && (done_id == run_id_o);
        unlink_en = done_wr && (done_id != run_id_o);
    end

    // Pending-clear request to the distributor on a successful claim.
    always_comb begin
        pend_clr_o     = ack_ok;
        pend_clr_id    = hp_id;
        pend_clr_all_o = ack_ok && irq_model_all[hp_id[$clog2(NUM_IRQ)-1:0]];
    end

    // Register read multiplexer.
    always_comb begin
        unique case (bus_addr)
            OFF_CTRL: bus_rdata = {31'd0, iface_en_o};
            OFF_MASK: bus_rdata = {24'd0, prio_mask_o};
            OFF_ACK:  bus_rdata = {22'd0, (ack_ok ? hp_id : NO_ID)};
            OFF_RUNP: bus_rdata = {23'd0, run_prio_o};
            OFF_HIGH: bus_rdata = {22'd0, hp_id};
            default:  bus_rdata = 32'd0;
        endcase
    end

    cpuif_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_xfer && (bus_addr == OFF_CTRL)),
        .wr_mask   (wr_xfer && (bus_addr == OFF_MASK)),
        .wdata     (bus_wdata),
        .iface_en  (iface_en_o),
        .prio_mask (prio_mask_o)
    );

    cpuif_reassert #(.NUM_IRQ(NUM_IRQ)) u_reassert (
        .done_en    (done_wr),
        .done_id    (done_id),
        .irq_edge   (irq_edge),
        .irq_enable (irq_enable),
        .irq_level  (irq_level),
        .irq_target (irq_target),
        .set_en     (pend_set_o),
        .set_id     (pend_set_id)
    );

    cpuif_nest_chain #(.NUM_IRQ(NUM_IRQ)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (ack_ok),
        .push_id   (hp_id),
        .push_prio (hp_prio),
        .pop_en    (pop_en),
        .unlink_en (unlink_en),
        .unlink_id (done_id),
        .run_id    (run_id_o),
        .run_prio  (run_prio_o),
        .busy      (busy)
    );
endmodule

// File: rtl/cpu_claim_if_sva.sv
// Checker for cpu_claim_if, attached by bind. Observes ports only.
module cpu_claim_if_sva #(
    parameter int NUM_IRQ = 64
)(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [4:0] bus_addr,
    input logic       bus_ready,
    input logic [9:0] hp_id,
    input logic [7:0] hp_prio,
    input logic       pend_clr_o,
    input logic       pend_set_o,
    input logic [9:0] run_id_o,
    input logic [8:0] run_prio_o
);
    // R1: reset leaves no running interrupt.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (run_id_o == 10'd1023 && run_prio_o == 9'h100));

    // R2: a claim only happens with a strictly more urgent pending ID.
    assert_ack_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_o |-> (hp_id != 10'd1023 && {1'b0, hp_prio} < run_prio_o));

    // R3: a claim makes the claimed ID and its priority current.
    assert_ack_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_o |=> (run_id_o == $past(hp_id) && run_prio_o == {1'b0, $past(hp_prio)}));

    // R5: completion with nothing running is inert.
    assert_idle_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_ready && bus_wr && bus_addr == 5'h10 && run_id_o == 10'd1023)
        |-> !pend_set_o);

    // R7: no running interrupt means the idle priority.
    assert_empty_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_id_o == 10'd1023 |-> run_prio_o == 9'h100);

    // R9: while the walk stalls the bus, the running state holds.
    assert_walk_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> ($stable(run_id_o) && $stable(run_prio_o)));

    // R8: a walk only ever runs beneath a real running interrupt.
    assert_walk_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> run_id_o != 10'd1023);
endmodule

bind cpu_claim_if cpu_claim_if_sva #(.NUM_IRQ(NUM_IRQ)) u_sva (.*);

// File: tb/cpu_claim_if_test.sv
module cpu_claim_if_test;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, bwr = 1'b0;
    logic [4:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic ready;
    logic [9:0] hp_id = 10'd1023;
    logic [7:0] hp_prio = '0;
    logic [N-1:0] edge_v = '0, en_v = '0, lvl_v = '0, tgt_v = '0, all_v = '0;
    logic clr, clr_all, pset, iface_en;
    logic [9:0] clr_id, pset_id, run_id;
    logic [7:0] mask;
    logic [8:0] run_prio;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    cpu_claim_if #(.NUM_IRQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(bwr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready),
        .hp_id(hp_id), .hp_prio(hp_prio), .irq_edge(edge_v), .irq_enable(en_v),
        .irq_level(lvl_v), .irq_target(tgt_v), .irq_model_all(all_v),
        .pend_clr_o(clr), .pend_clr_all_o(clr_all), .pend_clr_id(clr_id),
        .pend_set_o(pset), .pend_set_id(pset_id), .iface_en_o(iface_en),
        .prio_mask_o(mask), .run_id_o(run_id), .run_prio_o(run_prio)
    );

    typedef struct packed {
        logic [9:0] id;
        logic [7:0] prio;
        logic [9:0] exp_id;
        logic       exp_clr;
        logic       exp_all;
        logic [8:0] exp_rp;
    } ack_vec_t;

    // Claim sequence from reset; state carries over between rows.
    localparam ack_vec_t ACK_TAB [9] = '{
        '{10'd1023, 8'h00, 10'd1023, 1'b0, 1'b0, 9'h100},
        '{10'd5,    8'h80, 10'd5,    1'b1, 1'b0, 9'h080},
        '{10'd9,    8'h80, 10'd1023, 1'b0, 1'b0, 9'h080},
        '{10'd9,    8'h90, 10'd1023, 1'b0, 1'b0, 9'h080},
        '{10'd12,   8'h40, 10'd12,   1'b1, 1'b1, 9'h040},
        '{10'd70,   8'h00, 10'd1023, 1'b0, 1'b0, 9'h040},
        '{10'd20,   8'h10, 10'd20,   1'b1, 1'b0, 9'h010},
        '{10'd33,   8'h00, 10'd33,   1'b1, 1'b1, 9'h000},
        '{10'd40,   8'h00, 10'd1023, 1'b0, 1'b0, 9'h000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus transfer: drive at the falling edge, sample before the rising edge.
    logic [31:0] s_rd;
    logic s_clr, s_all, s_set;
    logic [9:0] s_clr_id, s_set_id;
    task automatic xfer(input logic w, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; bwr = w; addr = a; wdata = d;
        #1;
        while (!ready) begin @(negedge clk); #1; end
        s_rd = rdata; s_clr = clr; s_all = clr_all; s_clr_id = clr_id;
        s_set = pset; s_set_id = pset_id;
        @(posedge clk); #1;
        sel = 1'b0; bwr = 1'b0;
    endtask

    // Count cycles with ready low after an accepted transfer.
    int stall;
    task automatic count_stall();
        stall = 0;
        while (!ready && stall < 100) begin stall++; @(posedge clk); #1; end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        all_v[12] = 1'b1; all_v[33] = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        chk("R1 run_id", 32'(run_id), 32'd1023);
        xfer(1'b0, 5'h00, 0); chk("R1 enable", s_rd, 32'd0);
        xfer(1'b0, 5'h04, 0); chk("R1 mask", s_rd, 32'hf0);
        xfer(1'b0, 5'h14, 0); chk("R1 running prio", s_rd, 32'h100);

        // R2 R3 R4: claim table
        for (int i = 0; i < 9; i++) begin
            hp_id = ACK_TAB[i].id; hp_prio = ACK_TAB[i].prio;
            xfer(1'b0, 5'h0c, 0);
            chk($sformatf("R2 ack data row%0d", i), s_rd, 32'(ACK_TAB[i].exp_id));
            chk($sformatf("R2 clear pulse row%0d", i), 32'(s_clr), 32'(ACK_TAB[i].exp_clr));
            if (ACK_TAB[i].exp_clr) begin
                chk($sformatf("R2 clear id row%0d", i), 32'(s_clr_id), 32'(ACK_TAB[i].id));
                chk($sformatf("R4 clear all row%0d", i), 32'(s_all), 32'(ACK_TAB[i].exp_all));
            end
            xfer(1'b0, 5'h14, 0);
            chk($sformatf("R3 running prio row%0d", i), s_rd, 32'(ACK_TAB[i].exp_rp));
        end
        chk("R3 running id", 32'(run_id), 32'd33);

        // R8 R9: splice out ID 12, second entry below running 33
        xfer(1'b1, 5'h10, 32'd12);
        count_stall();
        chk("R9 stall found depth2", 32'(stall), 32'd2);
        chk("R8 running kept", 32'(run_id), 32'd33);

        // R7: complete running IDs in turn
        xfer(1'b1, 5'h10, 32'd33);
        chk("R6 no repend level low", 32'(s_set), 32'd0);
        xfer(1'b0, 5'h14, 0); chk("R7 prio after 33", s_rd, 32'h010);
        chk("R7 id after 33", 32'(run_id), 32'd20);
        xfer(1'b1, 5'h10, 32'd20);
        chk("R8 skip removed 12", 32'(run_id), 32'd5);
        xfer(1'b0, 5'h14, 0); chk("R8 prio after skip", s_rd, 32'h080);
        xfer(1'b1, 5'h10, 32'd5);
        chk("R7 empty id", 32'(run_id), 32'd1023);
        xfer(1'b0, 5'h14, 0); chk("R7 empty prio", s_rd, 32'h100);

        // R5: completion with nothing running
        en_v[7] = 1'b1; lvl_v[7] = 1'b1; tgt_v[7] = 1'b1;
        xfer(1'b1, 5'h10, 32'd7);
        chk("R5 no repend", 32'(s_set), 32'd0);
        chk("R5 ready stays high", 32'(ready), 32'd1);
        xfer(1'b0, 5'h14, 0); chk("R5 prio unchanged", s_rd, 32'h100);

        // R6: re-pend of a still-high level line
        hp_id = 10'd7; hp_prio = 8'h20;
        xfer(1'b0, 5'h0c, 0); chk("R6 claim 7", s_rd, 32'd7);
        xfer(1'b1, 5'h10, 32'd7);
        chk("R6 repend pulse", 32'(s_set), 32'd1);
        chk("R6 repend id", 32'(s_set_id), 32'd7);
        edge_v[7] = 1'b1;
        xfer(1'b0, 5'h0c, 0); chk("R6 reclaim 7", s_rd, 32'd7);
        xfer(1'b1, 5'h10, 32'd7);
        chk("R6 edge no repend", 32'(s_set), 32'd0);
        edge_v[7] = 1'b0; tgt_v[7] = 1'b0;
        xfer(1'b0, 5'h0c, 0);
        xfer(1'b1, 5'h10, 32'd7);
        chk("R6 untargeted no repend", 32'(s_set), 32'd0);

        // R9: walk for an ID not in the chain 8 -> 3
        hp_id = 10'd3; hp_prio = 8'h50; xfer(1'b0, 5'h0c, 0);
        hp_id = 10'd8; hp_prio = 8'h30; xfer(1'b0, 5'h0c, 0);
        xfer(1'b1, 5'h10, 32'd50);
        count_stall();
        chk("R9 stall absent", 32'(stall), 32'd2);
        chk("R8 running after miss", 32'(run_id), 32'd8);
        xfer(1'b1, 5'h10, 32'd8);
        chk("R7 pop to 3", 32'(run_id), 32'd3);

        // R10: control, mask and highest-pending registers
        xfer(1'b1, 5'h00, 32'd1);
        xfer(1'b0, 5'h00, 0); chk("R10 enable read", s_rd, 32'd1);
        chk("R10 enable port", 32'(iface_en), 32'd1);
        xfer(1'b1, 5'h04, 32'h1a5);
        xfer(1'b0, 5'h04, 0); chk("R10 mask read", s_rd, 32'ha5);
        hp_id = 10'h2b5;
        xfer(1'b0, 5'h18, 0); chk("R10 highest pending", s_rd, 32'h2b5);

        report();
    end
endmodule